// File: doc/BRIEF.md
# VC-12 Tandem Connection Sink Monitor

This block sits at the far end of a lower-order tandem connection. It takes the VC-12 byte stream one byte per valid cycle, together with a marker on the first byte (V5) of each 140-byte VC-12 multiframe. From each VC-12 multiframe it picks out the tandem connection overhead byte, which is the third path overhead byte at offset `2*ROW_BYTES` from the marker. It checks that byte against an even BIP-2 computed over the previous VC-12 multiframe. It flags a broken fixed-one bit and forwards the incoming-AIS, TC-REI and OEI indications.

Bits 7 and 8 of the overhead byte form a slow channel that repeats every 76 VC-12 multiframes. The block finds the phase of this channel from a fixed alignment word spread over its first eight frames. It declares lock and loss of lock with hysteresis. While locked, it reads the TC-RDI and ODI indications from one status frame near the end of the 76-frame cycle. Every result is registered and updated together with a one-cycle strobe after the overhead byte has been accepted.

Top module: `n2_tcm_sink`

## Requirements
- R1: The overhead byte is the valid byte at position `2*ROW_BYTES`, counting the marked byte as position 0. One cycle after that byte is accepted, `n2_stb_o` is high for exactly one cycle. It is low after every other byte.
- R2: `bip_err_o` gives the number of differing bits (0, 1 or 2) between bits 1..2 of the overhead byte (byte bits 7..6) and the even BIP-2 of all bytes of the previous VC-12 multiframe. BIP bit 1 is the XOR of byte bits 7,5,3,1 and BIP bit 2 is the XOR of byte bits 6,4,2,0.
- R3: In the first VC-12 multiframe after reset there is no previous multiframe, so `bip_err_o` reports 0.
- R4: `fixed_err_o` is 1 exactly when bit 3 of the overhead byte (byte bit 5) was received as 0.
- R5: `ais_o`, `rei_o` and `oei_o` copy bits 4, 5 and 6 of the overhead byte (byte bits 4, 3, 2). These outputs, `bip_err_o` and `fixed_err_o` hold their values between strobes.
- R6: The 76-frame channel is aligned when bits 7..8 of eight successive frames equal 11,11,11,11,11,11,11,10. After that match, the next frame is index 8. `lock_o` rises after two consecutive matches at the expected phase, and changes only on a strobe.
- R7: While locked, a single missed alignment word keeps lock. Two consecutive misses drop lock, and a new search then starts. While not locked, a miss at the candidate phase drops that candidate.
- R8: While locked, frame index `STATUS_FRAME` (default 72) loads `tc_rdi_o` from bit 7 (byte bit 1) and `odi_o` from bit 8 (byte bit 0). Both hold until the next such frame and are 0 whenever `lock_o` is 0.
- R9: After reset all outputs are 0.
- R10: A cycle with `valid_i` low is ignored entirely, including its byte and its marker. It causes no strobe and has no effect on parity or alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte valid |
| mfs_i | input | 1 | Marks the first byte of a VC-12 multiframe |
| byte_i | input | 8 | VC-12 byte, bit 7 is transmitted first |
| n2_stb_o | output | 1 | Results updated this cycle |
| bip_err_o | output | 2 | BIP-2 violations in the last overhead byte |
| fixed_err_o | output | 1 | Fixed-one bit received as 0 |
| ais_o | output | 1 | Incoming-AIS indication |
| rei_o | output | 1 | Tandem connection remote error indication |
| oei_o | output | 1 | Outgoing error indication |
| lock_o | output | 1 | 76-frame channel aligned |
| tc_rdi_o | output | 1 | Tandem connection remote defect indication |
| odi_o | output | 1 | Outgoing defect indication |

## Verification
The assertions check the following on every cycle:
- the strobe spacing and its dependence on a valid byte;
- the range of the BIP count;
- the fixed-bit flag and the flag copies against the byte accepted one cycle earlier;
- that all results hold between strobes, and that TC-RDI and ODI are zero without lock.

Only the bench scenarios can show the rest. These are the BIP-2 comparison across multiframes, the lock hysteresis over a sequence of good and corrupted alignment words, and the status frame sampled at the right phase. The bench covers them with patterns of injected parity errors, gaps and false markers.

// File: rtl/n2_tcm_pkg.sv
package n2_tcm_pkg;
  typedef struct packed {
    logic [1:0] bip;
    logic       fixed_one;
    logic       ais;
    logic       rei;
    logic       oei;
    logic [1:0] mf_bits;
  } n2_fields_t;

  function automatic logic [1:0] bip2_of(input logic [7:0] b);
    return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
  endfunction
endpackage

// File: rtl/n2_locator.sv
module n2_locator #(
  parameter int ROW_BYTES = 35
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       mfs_i,
  input  logic [7:0] byte_i,
  output logic       n2_hit_o,
  output logic [1:0] ref_bip_o,
  output logic       ref_ok_o
);
  import n2_tcm_pkg::*;
  localparam int FRAME_BYTES = 4 * ROW_BYTES;
  localparam int N2_POS      = 2 * ROW_BYTES;
  localparam int PW          = $clog2(FRAME_BYTES + 1);

  logic [PW-1:0] pos_q, cur_pos;
  logic          started_q;
  logic [1:0]    acc_q;

  assign cur_pos  = mfs_i ? '0 : pos_q;
  assign n2_hit_o = valid_i && (started_q || mfs_i) && (cur_pos == PW'(N2_POS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q     <= '0;
      started_q <= 1'b0;
      acc_q     <= '0;
      ref_bip_o <= '0;
      ref_ok_o  <= 1'b0;
    end else if (valid_i) begin
      if (mfs_i) begin
        started_q <= 1'b1;
        pos_q     <= PW'(1);
        acc_q     <= bip2_of(byte_i);
        ref_bip_o <= acc_q;
        ref_ok_o  <= started_q;
      end else if (started_q) begin
        // saturate so an overlong frame never revisits the overhead slot
        if (pos_q != PW'(FRAME_BYTES - 1)) pos_q <= pos_q + PW'(1);
        acc_q <= acc_q ^ bip2_of(byte_i);
      end
    end
  end
endmodule

// File: rtl/n2_field_check.sv
module n2_field_check (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [7:0] byte_i,
  input  logic [1:0] ref_bip_i,
  input  logic       ref_ok_i,
  output logic       stb_o,
  output logic [1:0] bip_err_o,
  output logic       fixed_err_o,
  output logic       ais_o,
  output logic       rei_o,
  output logic       oei_o
);
  import n2_tcm_pkg::*;
  n2_fields_t f;
  logic [1:0] diff, cnt;

  assign f    = n2_fields_t'(byte_i);
  assign diff = f.bip ^ ref_bip_i;
  assign cnt  = ref_ok_i ? {diff[1] & diff[0], diff[1] ^ diff[0]} : 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o       <= 1'b0;
      bip_err_o   <= '0;
      fixed_err_o <= 1'b0;
      ais_o       <= 1'b0;
      rei_o       <= 1'b0;
      oei_o       <= 1'b0;
    end else begin
      stb_o <= hit_i;
      if (hit_i) begin
        bip_err_o   <= cnt;
        fixed_err_o <= ~f.fixed_one;
        ais_o       <= f.ais;
        rei_o       <= f.rei;
        oei_o       <= f.oei;
      end
    end
  end
endmodule

// File: rtl/tc_mf_align.sv
module tc_mf_align #(
  parameter int          MF_LEN       = 76,
  parameter int          FAS_FRAMES   = 8,
  parameter logic [15:0] FAS_PAT      = 16'hFFFE,
  parameter int          STATUS_FRAME = 72,
  parameter int          LOCK_HITS    = 2,
  parameter int          LOSS_MISSES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hit_i,
  input  logic [1:0] mf_bits_i,
  output logic       lock_o,
  output logic       rdi_o,
  output logic       odi_o
);
  localparam int FW  = $clog2(MF_LEN);
  localparam int SRW = 2 * FAS_FRAMES;
  localparam int CMX = (LOCK_HITS > LOSS_MISSES) ? LOCK_HITS : LOSS_MISSES;
  localparam int CW  = $clog2(CMX + 1);

  logic [SRW-1:0] sr_q, sr_n;
  logic [FW-1:0]  pos_q;
  logic           cand_q, match;
  logic [CW-1:0]  hits_q, misses_q;

  assign sr_n  = {sr_q[SRW-3:0], mf_bits_i};
  assign match = (sr_n == FAS_PAT[SRW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      pos_q    <= '0;
      cand_q   <= 1'b0;
      hits_q   <= '0;
      misses_q <= '0;
      lock_o   <= 1'b0;
      rdi_o    <= 1'b0;
      odi_o    <= 1'b0;
    end else if (hit_i) begin
      sr_q  <= sr_n;
      pos_q <= (pos_q == FW'(MF_LEN - 1)) ? '0 : pos_q + FW'(1);
      if (!cand_q) begin
        if (match) begin
          cand_q   <= 1'b1;
          pos_q    <= FW'(FAS_FRAMES);
          hits_q   <= CW'(1);
          misses_q <= '0;
        end
      end else if (pos_q == FW'(FAS_FRAMES - 1)) begin
        if (match) begin
          misses_q <= '0;
          if (hits_q < CW'(LOCK_HITS)) hits_q <= hits_q + CW'(1);
          if (hits_q >= CW'(LOCK_HITS - 1)) lock_o <= 1'b1;
        end else begin
          hits_q <= '0;
          if (!lock_o) begin
            cand_q <= 1'b0;
          end else if (misses_q >= CW'(LOSS_MISSES - 1)) begin
            lock_o   <= 1'b0;
            cand_q   <= 1'b0;
            misses_q <= '0;
            rdi_o    <= 1'b0;
            odi_o    <= 1'b0;
          end else begin
            misses_q <= misses_q + CW'(1);
          end
        end
      end else if (lock_o && pos_q == FW'(STATUS_FRAME)) begin
        rdi_o <= mf_bits_i[1];
        odi_o <= mf_bits_i[0];
      end
    end
  end
endmodule

// File: rtl/n2_tcm_sink.sv
module n2_tcm_sink #(
  parameter int ROW_BYTES    = 35,
  parameter int MF_LEN       = 76,
  parameter int STATUS_FRAME = 72
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       mfs_i,
  input  logic [7:0] byte_i,
  output logic       n2_stb_o,
  output logic [1:0] bip_err_o,
  output logic       fixed_err_o,
  output logic       ais_o,
  output logic       rei_o,
  output logic       oei_o,
  output logic       lock_o,
  output logic       tc_rdi_o,
  output logic       odi_o
);
  logic       n2_hit, ref_ok;
  logic [1:0] ref_bip;

  n2_locator #(.ROW_BYTES(ROW_BYTES)) u_loc (
    .clk_i, .rst_ni, .valid_i, .mfs_i, .byte_i,
    .n2_hit_o(n2_hit), .ref_bip_o(ref_bip), .ref_ok_o(ref_ok)
  );

  n2_field_check u_fld (
    .clk_i, .rst_ni, .hit_i(n2_hit), .byte_i,
    .ref_bip_i(ref_bip), .ref_ok_i(ref_ok),
    .stb_o(n2_stb_o), .bip_err_o, .fixed_err_o, .ais_o, .rei_o, .oei_o
  );

  tc_mf_align #(.MF_LEN(MF_LEN), .STATUS_FRAME(STATUS_FRAME)) u_aln (
    .clk_i, .rst_ni, .hit_i(n2_hit), .mf_bits_i(byte_i[1:0]),
    .lock_o, .rdi_o(tc_rdi_o), .odi_o
  );
endmodule

// File: rtl/n2_tcm_sink_chk.sv
module n2_tcm_sink_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       mfs_i,
  input logic [7:0] byte_i,
  input logic       n2_stb_o,
  input logic [1:0] bip_err_o,
  input logic       fixed_err_o,
  input logic       ais_o,
  input logic       rei_o,
  input logic       oei_o,
  input logic       lock_o,
  input logic       tc_rdi_o,
  input logic       odi_o
);
  p_stb_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n2_stb_o |=> !n2_stb_o);
  p_stb_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !n2_stb_o);
  p_bip_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bip_err_o != 2'b11);
  p_fixed_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n2_stb_o |-> (fixed_err_o == !$past(byte_i[5])));
  p_flag_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n2_stb_o |-> ({ais_o, rei_o, oei_o} == $past(byte_i[4:2])));
  p_flag_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n2_stb_o |-> $stable({bip_err_o, fixed_err_o, ais_o, rei_o, oei_o}));
  p_lock_on_stb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n2_stb_o |-> $stable(lock_o));
  p_status_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (!tc_rdi_o && !odi_o));
  p_status_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !n2_stb_o |-> $stable({tc_rdi_o, odi_o}));
endmodule

bind n2_tcm_sink n2_tcm_sink_chk u_chk (.*);

// File: tb/n2_tcm_sink_test.sv
module n2_tcm_sink_test;
  localparam int ROW = 5;
  localparam int FB  = 4 * ROW;
  localparam int N2P = 2 * ROW;
  localparam int MFL = 76;
  localparam int STF = 72;
  localparam int NMF = 6;

  logic       clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, mfs_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       n2_stb_o, fixed_err_o, ais_o, rei_o, oei_o, lock_o, tc_rdi_o, odi_o;
  logic [1:0] bip_err_o;

  n2_tcm_sink #(.ROW_BYTES(ROW), .MF_LEN(MFL), .STATUS_FRAME(STF)) uut (
    .clk_i, .rst_ni, .valid_i, .mfs_i, .byte_i, .n2_stb_o, .bip_err_o,
    .fixed_err_o, .ais_o, .rei_o, .oei_o, .lock_o, .tc_rdi_o, .odi_o
  );

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0;
  logic [31:0] lcg = 32'h1357_2468;
  int pend = 0;
  int e_bip, e_fix, e_flags, e_lock = 0, e_rdi = 0, e_odi = 0;
  logic [1:0] prev_bip = 2'b00;
  bit   good_tab [NMF] = '{1, 1, 0, 0, 1, 1};
  bit   lock_tab [NMF] = '{0, 1, 1, 0, 0, 1};
  logic [1:0] stat_tab [NMF] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b01};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [7:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  function automatic logic [1:0] bip2(input logic [7:0] b);
    return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
  endfunction

  task automatic do_check();
    if (pend == 1) chk(n2_stb_o == 1'b0, "R1/R10 no strobe", int'(n2_stb_o), 0);
    if (pend == 2) begin
      chk(n2_stb_o == 1'b1, "R1 strobe", int'(n2_stb_o), 1);
      chk(int'(bip_err_o) == e_bip, "R2/R3 bip count", int'(bip_err_o), e_bip);
      chk(int'(fixed_err_o) == e_fix, "R4 fixed bit", int'(fixed_err_o), e_fix);
      chk(int'({ais_o, rei_o, oei_o}) == e_flags, "R5 flags", int'({ais_o, rei_o, oei_o}), e_flags);
      chk(int'(lock_o) == e_lock, "R6/R7 lock", int'(lock_o), e_lock);
      chk(int'(tc_rdi_o) == e_rdi, "R8 tc_rdi", int'(tc_rdi_o), e_rdi);
      chk(int'(odi_o) == e_odi, "R8 odi", int'(odi_o), e_odi);
    end
    pend = 0;
  endtask

  task automatic put(input logic [7:0] b, input logic v, input logic m, input int kind);
    @(negedge clk_i);
    do_check();
    pend    = kind;
    valid_i = v;
    mfs_i   = m;
    byte_i  = b;
  endtask

  task automatic send_frame(input int g, input int m, input int f);
    logic [1:0] inj, mfb, acc;
    logic [7:0] n2, b;
    inj = (g % 3 == 0) ? 2'b00 : (g % 3 == 1) ? 2'b01 : 2'b11;
    if (f < 8) mfb = (f == 7) ? 2'b10 : 2'b11;
    else if (f == STF) mfb = stat_tab[m];
    else mfb = 2'b00;
    if (!good_tab[m] && f == 3) mfb = 2'b00;
    n2 = {prev_bip ^ inj, (g % 5 != 0), 3'((g * 3) % 8), mfb};
    acc = 2'b00;
    for (int j = 0; j < FB; j++) begin
      b = (j == N2P) ? n2 : rnd();
      acc = acc ^ bip2(b);
      // R10: an ignored cycle carrying a false marker
      if (j % 7 == 3) put(rnd(), 1'b0, 1'b1, 1);
      if (j == N2P) begin
        e_bip   = (g == 0) ? 0 : ((inj == 2'b11) ? 2 : (inj == 2'b01) ? 1 : 0);
        e_fix   = (g % 5 == 0) ? 1 : 0;
        e_flags = (g * 3) % 8;
        if (f == 7) begin
          if (e_lock == 1 && lock_tab[m] == 0) begin
            e_rdi = 0;
            e_odi = 0;
          end
          e_lock = int'(lock_tab[m]);
        end
        if (f == STF && e_lock == 1) begin
          e_rdi = int'(stat_tab[m][1]);
          e_odi = int'(stat_tab[m][0]);
        end
      end
      put(b, 1'b1, j == 0, (j == N2P) ? 2 : 1);
    end
    prev_bip = acc;
  endtask

  initial begin
    #(8 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({n2_stb_o, bip_err_o, fixed_err_o, ais_o, rei_o, oei_o, lock_o, tc_rdi_o, odi_o} == '0,
        "R9 reset outputs", int'({n2_stb_o, bip_err_o, fixed_err_o, ais_o, rei_o, oei_o,
        lock_o, tc_rdi_o, odi_o}), 0);
    rst_ni = 1'b1;
    for (int m = 0; m < NMF; m++)
      for (int f = 0; f < MFL; f++)
        send_frame(m * MFL + f, m, f);
    put(8'h00, 1'b0, 1'b0, 1);
    @(negedge clk_i);
    do_check();
    summary();
  end
endmodule